// File: doc/BRIEF.md
# In-Bank SIMD Instruction Sequencer

This block is the control core of one processing unit that sits beside a memory bank. A short program of 32-bit instructions is held in a local command store, which is loaded through a plain write port. The program has no fetch clock of its own. It advances only when the memory side signals a read or write access to the bank, and each such access (a trigger) runs exactly one instruction. The block owns two vector register files, each entry 16 lanes of 16 bits, and two small scalar register files, one for additive terms and one for multiplier terms. Scalars are broadcast to all lanes when they are used as operands.

On a read trigger, the data fetched from the bank is available as an operand. On a write trigger, the instruction's result becomes the data stored into the bank. Lane arithmetic is done by an external combinational unit. The sequencer presents the opcode and three operand vectors to it and takes back the result in the same cycle. An address-aligned flag in an instruction makes the register indices follow the access address, so the register chosen always tracks the bank column or row being touched. Loops are built from a counted backward jump. This jump is resolved in the same cycle as the trigger, so it never uses up an access. A terminating instruction parks the program until the program counter is cleared.

Top module: `bank_simd_seq`

## Requirements
- R1: After reset, `pc` is 0, `done` is 0 and `bank_we` is 0. Every register-file entry reads as zero.
- R2: The command word has these fields: opcode [31:28], destination type [27:26], destination index [25:23], source-0 type [22:21], source-0 index [20:18], source-1 type [17:16], source-1 index [15:13], aligned flag [12], jump count [9:5], jump offset [4:0]. The opcodes are NOP 0, MOV 1, FILL 2, ADD 3, MUL 4, MAC 5, JUMP 6, EXIT 7. Each cycle with `trig_rd` or `trig_wr` high executes one instruction and advances `pc` by one; with no trigger, `pc` holds. `prog_we` writes `prog_data` at `prog_addr`.
- R3: The register types are 0 vector file A, 1 vector file B, 2 scalar file, 3 bank. An instruction with destination type 3, executed on a write trigger, asserts `bank_we` for one cycle after the trigger, with the result on `bank_wdata`.
- R4: FILL copies `bank_rdata` into the destination on a read trigger. A bank operand reads as zero on a write trigger. A bank destination on a read trigger writes nothing.
- R5: MOV copies source 0 unchanged to the destination.
- R6: ADD, MUL and MAC place their opcode on `alu_op`, source 0 on `alu_a`, source 1 on `alu_b` and the destination's pre-trigger value on `alu_c`, all in the trigger cycle. `alu_res` is written to the destination. MAC therefore accumulates lane by lane into the same vector.
- R7: In the scalar file, index bit 2 selects the multiplier file (1) or the additive file (0), and bits 1:0 select the entry. A scalar source is broadcast to all 16 lanes. A scalar destination takes lane 0 of the result.
- R8: With the aligned flag set, every vector index is taken from `acc_col[2:0]`, and every scalar entry is taken from `acc_row[1:0]` (index bit 2 still comes from the instruction).
- R9: A JUMP with count N and offset k at address p branches to p-k on its first N visits and falls through on the next visit. In both cases the instruction at the branch target, or at p+1 on fall-through, executes on that same trigger, and `pc` then points after it.
- R10: EXIT sets `done` and leaves `pc` at the EXIT address. While `done` is high, triggers change no register, no `pc` and no bank write.
- R11: `pc_clear` sets `pc` to 0, clears `done` and disarms the jump counter, overriding any trigger in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Command store write enable |
| prog_addr | input | 5 | Command store write address |
| prog_data | input | 32 | Command word to store |
| pc_clear | input | 1 | Return program counter to 0 and leave the parked state |
| trig_rd | input | 1 | Bank read access (trigger) |
| trig_wr | input | 1 | Bank write access (trigger) |
| acc_row | input | 14 | Row address of the access |
| acc_col | input | 6 | Column address of the access |
| bank_rdata | input | 256 | Bank data of a read access, 16 lanes |
| alu_op | output | 4 | Opcode to the lane arithmetic unit |
| alu_a | output | 256 | Operand A to the lane arithmetic unit |
| alu_b | output | 256 | Operand B to the lane arithmetic unit |
| alu_c | output | 256 | Accumulator operand (destination's current value) |
| alu_res | input | 256 | Result from the lane arithmetic unit |
| bank_we | output | 1 | Registered bank write strobe |
| bank_wdata | output | 256 | Registered data to store into the bank |
| pc | output | 5 | Program counter |
| done | output | 1 | Program has reached EXIT |

## Verification
On every cycle, the assertions check several invariants. The program counter holds without a trigger. A parked program keeps `done` and `pc` frozen. A clear always lands on address 0. A bank write strobe only ever follows a write trigger that was taken while not parked. Some properties are left to the bench scenarios because they depend on data values: the operand routing through the external arithmetic unit, the read-before-write behaviour of MAC, scalar broadcast, address-derived indices, the exact iteration count of a loop and the same-trigger execution of a jump target. The bench covers these with known lane patterns and a queue of expected bank writes.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 3;
  localparam int JFLD_W  = 5;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_MOV  = 4'd1,
    OP_FILL = 4'd2,
    OP_ADD  = 4'd3,
    OP_MUL  = 4'd4,
    OP_MAC  = 4'd5,
    OP_JUMP = 4'd6,
    OP_EXIT = 4'd7
  } op_e;

  typedef enum logic [1:0] {
    RT_GA = 2'd0,
    RT_GB = 2'd1,
    RT_SR = 2'd2,
    RT_BK = 2'd3
  } rtype_e;

  typedef struct packed {
    op_e               op;
    rtype_e            dt;
    logic [IDX_W-1:0]  di;
    rtype_e            s0t;
    logic [IDX_W-1:0]  s0i;
    rtype_e            s1t;
    logic [IDX_W-1:0]  s1i;
    logic              aam;
    logic [1:0]        rsv;
    logic [JFLD_W-1:0] jcount;
    logic [JFLD_W-1:0] joff;
  } instr_t;
endpackage

// File: rtl/seq_cmd_store.sv
module seq_cmd_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/seq_flow_ctl.sv
module seq_flow_ctl
  import simd_seq_pkg::*;
#(
  parameter int PCW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           trig,
  input  instr_t         ia,
  input  op_e            op_b,
  output logic [PCW-1:0] pc,
  output logic [PCW-1:0] epc,
  output logic           done,
  output logic           exec
);
  logic              jarm;
  logic [JFLD_W-1:0] jleft;
  logic              is_jmp, take;

  assign is_jmp = (ia.op == OP_JUMP);
  assign take   = is_jmp && (jarm ? (jleft != '0) : (ia.jcount != '0));
  assign exec   = trig && !done && !clr;

  always_comb begin
    if (!is_jmp)   epc = pc;
    else if (take) epc = pc - PCW'(ia.joff);
    else           epc = pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc    <= '0;
      done  <= 1'b0;
      jarm  <= 1'b0;
      jleft <= '0;
    end else if (exec) begin
      if (is_jmp) begin
        if (!jarm) begin
          if (ia.jcount != '0) begin
            jarm  <= 1'b1;
            jleft <= ia.jcount - 1'b1;
          end
        end else if (jleft == '0) begin
          jarm <= 1'b0;
        end else begin
          jleft <= jleft - 1'b1;
        end
      end
      if (op_b == OP_EXIT) begin
        done <= 1'b1;
        pc   <= epc;
      end else begin
        pc <= epc + 1'b1;
      end
    end
  end

  a_r2_idle_pc_holds: assert property (@(posedge clk) disable iff (rst)
    (!trig && !clr) |=> $stable(pc));
  a_r10_parked_frozen: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> (done && $stable(pc)));
  a_r11_clear_lands_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pc == '0 && !done));
endmodule

// File: rtl/seq_reg_files.sv
module seq_reg_files
  import simd_seq_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int DW     = 16,
  parameter int GDEPTH = 8,
  parameter int SDEPTH = 4,
  localparam int VW  = LANES * DW,
  localparam int GIW = $clog2(GDEPTH),
  localparam int SIW = $clog2(SDEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  rtype_e           wt,
  input  logic [IDX_W-1:0] wi,
  input  logic [VW-1:0]    wv,
  input  rtype_e           s0t,
  input  logic [IDX_W-1:0] s0i,
  input  rtype_e           s1t,
  input  logic [IDX_W-1:0] s1i,
  input  rtype_e           dt,
  input  logic [IDX_W-1:0] di,
  input  logic [VW-1:0]    bank_v,
  output logic [VW-1:0]    v0,
  output logic [VW-1:0]    v1,
  output logic [VW-1:0]    vd
);
  logic [VW-1:0] gra [GDEPTH];
  logic [VW-1:0] grb [GDEPTH];
  logic [DW-1:0] sra [SDEPTH];
  logic [DW-1:0] srm [SDEPTH];

  function automatic logic [VW-1:0] fetch(rtype_e t, logic [IDX_W-1:0] i);
    case (t)
      RT_GA:   fetch = gra[i[GIW-1:0]];
      RT_GB:   fetch = grb[i[GIW-1:0]];
      RT_SR:   fetch = {LANES{i[IDX_W-1] ? srm[i[SIW-1:0]] : sra[i[SIW-1:0]]}};
      default: fetch = bank_v;
    endcase
  endfunction

  always_comb begin
    v0 = fetch(s0t, s0i);
    v1 = fetch(s1t, s1i);
    vd = fetch(dt, di);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < GDEPTH; g++) begin
        gra[g] <= '0;
        grb[g] <= '0;
      end
      for (int s = 0; s < SDEPTH; s++) begin
        sra[s] <= '0;
        srm[s] <= '0;
      end
    end else if (we) begin
      case (wt)
        RT_GA: gra[wi[GIW-1:0]] <= wv;
        RT_GB: grb[wi[GIW-1:0]] <= wv;
        RT_SR: begin
          if (wi[IDX_W-1]) srm[wi[SIW-1:0]] <= wv[DW-1:0];
          else             sra[wi[SIW-1:0]] <= wv[DW-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bank_simd_seq.sv
module bank_simd_seq
  import simd_seq_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int DW        = 16,
  parameter int CRF_DEPTH = 32,
  parameter int GDEPTH    = 8,
  parameter int SDEPTH    = 4,
  parameter int ROW_W     = 14,
  parameter int COL_W     = 6,
  localparam int VW  = LANES * DW,
  localparam int PCW = $clog2(CRF_DEPTH),
  localparam int GIW = $clog2(GDEPTH),
  localparam int SIW = $clog2(SDEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [PCW-1:0]     prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic               pc_clear,
  input  logic               trig_rd,
  input  logic               trig_wr,
  input  logic [ROW_W-1:0]   acc_row,
  input  logic [COL_W-1:0]   acc_col,
  input  logic [VW-1:0]      bank_rdata,
  output logic [3:0]         alu_op,
  output logic [VW-1:0]      alu_a,
  output logic [VW-1:0]      alu_b,
  output logic [VW-1:0]      alu_c,
  input  logic [VW-1:0]      alu_res,
  output logic               bank_we,
  output logic [VW-1:0]      bank_wdata,
  output logic [PCW-1:0]     pc,
  output logic               done
);
  logic [INSTR_W-1:0] word_a, word_b;
  instr_t             ia, ib;
  logic [PCW-1:0]     epc;
  logic               exec, trig, is_op, exe;
  logic [VW-1:0]      bank_op, v0, v1, vd, result;
  logic [IDX_W-1:0]   e_di, e_s0i, e_s1i;

  assign trig = trig_rd || trig_wr;

  seq_cmd_store #(.DEPTH(CRF_DEPTH), .WIDTH(INSTR_W)) u_store (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr_a(pc), .raddr_b(epc), .rdata_a(word_a), .rdata_b(word_b)
  );

  assign ia = instr_t'(word_a);
  assign ib = instr_t'(word_b);

  seq_flow_ctl #(.PCW(PCW)) u_flow (
    .clk(clk), .rst(rst), .clr(pc_clear), .trig(trig), .ia(ia), .op_b(ib.op),
    .pc(pc), .epc(epc), .done(done), .exec(exec)
  );

  // address-aligned index substitution
  function automatic logic [IDX_W-1:0] align_idx(rtype_e t, logic [IDX_W-1:0] i, logic aam);
    logic [IDX_W-1:0] r;
    r = i;
    if (aam) begin
      if (t == RT_SR) r[SIW-1:0] = acc_row[SIW-1:0];
      else            r = IDX_W'(acc_col[GIW-1:0]);
    end
    return r;
  endfunction

  assign e_di  = align_idx(ib.dt,  ib.di,  ib.aam);
  assign e_s0i = align_idx(ib.s0t, ib.s0i, ib.aam);
  assign e_s1i = align_idx(ib.s1t, ib.s1i, ib.aam);

  assign bank_op = trig_rd ? bank_rdata : '0;

  seq_reg_files #(.LANES(LANES), .DW(DW), .GDEPTH(GDEPTH), .SDEPTH(SDEPTH)) u_rf (
    .clk(clk), .rst(rst),
    .we(exe && ib.dt != RT_BK), .wt(ib.dt), .wi(e_di), .wv(result),
    .s0t(ib.s0t), .s0i(e_s0i), .s1t(ib.s1t), .s1i(e_s1i),
    .dt(ib.dt), .di(e_di), .bank_v(bank_op),
    .v0(v0), .v1(v1), .vd(vd)
  );

  always_comb begin
    is_op = 1'b1;
    case (ib.op)
      OP_MOV:                 result = v0;
      OP_FILL:                result = bank_op;
      OP_ADD, OP_MUL, OP_MAC: result = alu_res;
      default: begin
        result = '0;
        is_op  = 1'b0;
      end
    endcase
  end

  assign exe    = exec && is_op;
  assign alu_op = ib.op;
  assign alu_a  = v0;
  assign alu_b  = v1;
  assign alu_c  = vd;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_we    <= 1'b0;
      bank_wdata <= '0;
    end else begin
      bank_we <= exe && (ib.dt == RT_BK) && trig_wr && !trig_rd;
      if (exe && (ib.dt == RT_BK) && trig_wr && !trig_rd) bank_wdata <= result;
    end
  end

  a_r3_write_follows_wr: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> $past(trig_wr && !trig_rd));
  a_r10_no_write_when_parked: assert property (@(posedge clk) disable iff (rst)
    bank_we |-> !$past(done));
endmodule

// File: tb/sim_bank_simd_seq.sv
module sim_bank_simd_seq;
  localparam int VW = 256;
  typedef logic [VW-1:0] vec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [4:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic        pc_clear = 1'b0;
  logic        trig_rd = 1'b0, trig_wr = 1'b0;
  logic [13:0] acc_row = '0;
  logic [5:0]  acc_col = '0;
  vec_t        bank_rdata = '0;
  logic [3:0]  alu_op;
  vec_t        alu_a, alu_b, alu_c, alu_res, bank_wdata;
  logic        bank_we, done;
  logic [4:0]  pc;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  vec_t  exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  bank_simd_seq u0 (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pc_clear(pc_clear), .trig_rd(trig_rd),
    .trig_wr(trig_wr), .acc_row(acc_row), .acc_col(acc_col),
    .bank_rdata(bank_rdata), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
    .alu_c(alu_c), .alu_res(alu_res), .bank_we(bank_we),
    .bank_wdata(bank_wdata), .pc(pc), .done(done)
  );

  // external lane arithmetic model: 3 add, 4 multiply, 5 multiply-accumulate
  always_comb begin
    for (int i = 0; i < 16; i++) begin
      case (alu_op)
        4'd3:    alu_res[i*16 +: 16] = alu_a[i*16 +: 16] + alu_b[i*16 +: 16];
        4'd4:    alu_res[i*16 +: 16] = alu_a[i*16 +: 16] * alu_b[i*16 +: 16];
        4'd5:    alu_res[i*16 +: 16] = alu_c[i*16 +: 16] + alu_a[i*16 +: 16] * alu_b[i*16 +: 16];
        default: alu_res[i*16 +: 16] = alu_a[i*16 +: 16];
      endcase
    end
  end

  function automatic vec_t lanes(int base, int step);
    vec_t v;
    for (int i = 0; i < 16; i++) v[i*16 +: 16] = 16'(base + step * i);
    return v;
  endfunction
  function automatic vec_t vop(vec_t a, vec_t b, vec_t c, int kind);
    vec_t v;
    for (int i = 0; i < 16; i++) begin
      if (kind == 0)      v[i*16 +: 16] = a[i*16 +: 16] + b[i*16 +: 16];
      else if (kind == 1) v[i*16 +: 16] = a[i*16 +: 16] * b[i*16 +: 16];
      else                v[i*16 +: 16] = c[i*16 +: 16] + a[i*16 +: 16] * b[i*16 +: 16];
    end
    return v;
  endfunction
  function automatic logic [31:0] enc(int op, int dt, int di, int s0t, int s0i,
                                      int s1t, int s1i, int aam, int cnt, int off);
    return {4'(op), 2'(dt), 3'(di), 2'(s0t), 3'(s0i), 2'(s1t), 3'(s1i),
            1'(aam), 2'b00, 5'(cnt), 5'(off)};
  endfunction

  task automatic check(bit ok, string tag, string what, int got, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bank_we) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected bank write: got %h expected none", bank_wdata);
      end else begin
        vec_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bank_wdata !== e) begin
          fails++;
          $display("FAIL %s bank data: got %h expected %h", t, bank_wdata, e);
        end
      end
    end
  end

  task automatic load(int addr, logic [31:0] w);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 5'(addr); prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic fire(bit rd, bit wr, int row, int col, vec_t bv,
                      bit expw, vec_t ev, string tag);
    @(negedge clk);
    trig_rd = rd; trig_wr = wr;
    acc_row = 14'(row); acc_col = 6'(col); bank_rdata = bv;
    if (expw) begin
      exp_q.push_back(ev);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    trig_rd = 1'b0; trig_wr = 1'b0;
  endtask

  task automatic clear_pc();
    @(negedge clk);
    pc_clear = 1'b1;
    @(negedge clk);
    pc_clear = 1'b0;
  endtask

  task automatic drain(string tag);
    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, tag, "pending writes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t va, vb, z, ones, v;
    va = lanes(100, 3); vb = lanes(7, 1); z = '0; ones = lanes(1, 0); v = lanes(10, 2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pc == 0, "R1", "pc after reset", pc, 0);
    check(done == 0, "R1", "done after reset", done, 0);
    check(bank_we == 0, "R1", "bank_we after reset", bank_we, 0);

    // program 1: data movement, arithmetic, scalars, aligned mode, exit
    load(0,  enc(2, 0, 1, 3, 0, 0, 0, 0, 0, 0)); // FILL GA1
    load(1,  enc(2, 1, 2, 3, 0, 0, 0, 0, 0, 0)); // FILL GB2
    load(2,  enc(3, 0, 3, 0, 1, 1, 2, 0, 0, 0)); // ADD GA3=GA1+GB2
    load(3,  enc(1, 3, 0, 0, 3, 0, 0, 0, 0, 0)); // MOV BANK<-GA3
    load(4,  enc(4, 3, 0, 0, 1, 1, 2, 0, 0, 0)); // MUL BANK=GA1*GB2
    load(5,  enc(5, 0, 1, 0, 1, 1, 2, 0, 0, 0)); // MAC GA1+=GA1*GB2
    load(6,  enc(1, 3, 0, 0, 1, 0, 0, 0, 0, 0)); // MOV BANK<-GA1
    load(7,  enc(2, 0, 2, 3, 0, 0, 0, 0, 0, 0)); // FILL GA2 on write
    load(8,  enc(1, 3, 0, 0, 2, 0, 0, 0, 0, 0)); // MOV BANK<-GA2
    load(9,  enc(1, 3, 0, 1, 2, 0, 0, 0, 0, 0)); // MOV BANK<-GB2 on read
    load(10, enc(1, 2, 1, 0, 3, 0, 0, 0, 0, 0)); // MOV SRF-A1<-GA3
    load(11, enc(1, 2, 6, 1, 2, 0, 0, 0, 0, 0)); // MOV SRF-M2<-GB2
    load(12, enc(3, 3, 0, 2, 1, 2, 6, 0, 0, 0)); // ADD BANK=SA1+SM2
    load(13, enc(1, 3, 0, 0, 0, 0, 0, 1, 0, 0)); // aligned MOV BANK<-GA[col]
    load(14, enc(1, 3, 0, 0, 0, 0, 0, 1, 0, 0));
    load(15, enc(1, 3, 0, 2, 0, 0, 0, 1, 0, 0)); // aligned MOV BANK<-SA[row]
    load(16, enc(7, 0, 0, 0, 0, 0, 0, 0, 0, 0)); // EXIT
    clear_pc();

    fire(1, 0, 0, 0, va, 0, z, "R4");
    fire(1, 0, 0, 0, vb, 0, z, "R4");
    fire(1, 0, 0, 0, z, 0, z, "R6");
    fire(0, 1, 0, 0, z, 1, vop(va, vb, z, 0), "R5");
    check(pc == 4, "R2", "pc after four triggers", pc, 4);
    repeat (3) @(negedge clk);
    check(pc == 4, "R2", "pc while idle", pc, 4);
    fire(0, 1, 0, 0, z, 1, vop(va, vb, z, 1), "R6");
    fire(1, 0, 0, 0, z, 0, z, "R6");
    fire(0, 1, 0, 0, z, 1, vop(va, vb, va, 2), "R6");
    fire(0, 1, 0, 0, va, 0, z, "R4");
    fire(0, 1, 0, 0, z, 1, z, "R4");
    fire(1, 0, 0, 0, va, 0, z, "R4");
    drain("R4");
    fire(1, 0, 0, 0, z, 0, z, "R7");
    fire(1, 0, 0, 0, z, 0, z, "R7");
    fire(0, 1, 0, 0, z, 1, lanes(114, 0), "R7");
    fire(0, 1, 0, 3, z, 1, vop(va, vb, z, 0), "R8");
    fire(0, 1, 0, 1, z, 1, vop(va, vb, va, 2), "R8");
    fire(0, 1, 1, 0, z, 1, lanes(107, 0), "R8");
    fire(0, 1, 0, 0, z, 0, z, "R10");
    @(negedge clk);
    check(done == 1, "R10", "done at exit", done, 1);
    check(pc == 16, "R10", "pc at exit", pc, 16);
    fire(0, 1, 0, 0, z, 0, z, "R10");
    drain("R10");
    check(pc == 16, "R10", "pc after ignored trigger", pc, 16);
    check(done == 1, "R10", "done held", done, 1);
    clear_pc();
    check(pc == 0, "R11", "pc after clear", pc, 0);
    check(done == 0, "R11", "done after clear", done, 0);

    // program 2: counted loop, count 2 offset 2
    load(0, enc(2, 0, 7, 3, 0, 0, 0, 0, 0, 0)); // FILL GA7
    load(1, enc(2, 0, 0, 3, 0, 0, 0, 0, 0, 0)); // FILL GA0
    load(2, enc(3, 0, 0, 0, 0, 0, 7, 0, 0, 0)); // ADD GA0=GA0+GA7
    load(3, enc(1, 3, 0, 0, 0, 0, 0, 0, 0, 0)); // MOV BANK<-GA0
    load(4, enc(6, 0, 0, 0, 0, 0, 0, 0, 2, 2)); // JUMP x2 back 2
    load(5, enc(1, 3, 0, 1, 2, 0, 0, 0, 0, 0)); // MOV BANK<-GB2
    load(6, enc(7, 0, 0, 0, 0, 0, 0, 0, 0, 0)); // EXIT
    clear_pc();
    fire(1, 0, 0, 0, ones, 0, z, "R9");
    fire(1, 0, 0, 0, v, 0, z, "R9");
    fire(1, 0, 0, 0, z, 0, z, "R9");
    fire(0, 1, 0, 0, z, 1, vop(v, ones, z, 0), "R9");
    fire(1, 0, 0, 0, z, 0, z, "R9");
    check(pc == 3, "R9", "pc after taken jump", pc, 3);
    fire(0, 1, 0, 0, z, 1, lanes(12, 2), "R9");
    fire(1, 0, 0, 0, z, 0, z, "R9");
    fire(0, 1, 0, 0, z, 1, lanes(13, 2), "R9");
    fire(0, 1, 0, 0, z, 1, vb, "R9");
    check(pc == 6, "R9", "pc after fall-through", pc, 6);
    fire(0, 1, 0, 0, z, 0, z, "R10");
    drain("R9");
    check(done == 1 && pc == 6, "R10", "parked at loop exit", pc, 6);

    // reset returns everything to zero: read GA0 back through the bank
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(pc == 0 && done == 0, "R1", "pc after second reset", pc, 0);
    load(0, enc(1, 3, 0, 0, 0, 0, 0, 0, 0, 0));
    fire(0, 1, 0, 0, z, 1, z, "R1");
    drain("R1");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule